// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synchronous static RAM with 64-bit words. Every input is captured in an input register on the rising clock edge. An address strobe begins a burst of up to four accesses from one supplied address. After that, an advance input steps a two-bit beat counter that produces the two low address bits. The beat order is either interleaved, where the low bits are the start bits XOR the beat number, or linear, where they are the start bits plus the beat number modulo 4. The depth is a parameter, so a simulation can use a small array.

A write can set all eight bytes at once with the global write input. It can instead set selected byte lanes with the byte write enable and the lane select bits. A cycle that writes no byte is a read. Read data leaves the array through a registered read port. It then either flows straight to the output or passes through one extra output register, depending on a mode input.

The output drive is gated without any clock by the output enable and by the snooze input. While snooze is sampled active, no access takes effect and the burst state holds.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and after its release, `dq_en` is low and `dq_out` is zero until a read returns data.
- R2: An access cycle with `addr_strobe` high reaches the word at `addr` and clears the beat counter to 0.
- R3: An access cycle with `advance` high and `addr_strobe` low moves the beat counter on by one, modulo 4. After four steps the burst revisits its start word.
- R4: With `interleave_mode` = 1, the beat address keeps the upper start bits and uses low bits = start[1:0] XOR beat.
- R5: With `interleave_mode` = 0, the beat address keeps the upper start bits and uses low bits = (start[1:0] + beat) mod 4.
- R6: `wr_all` = 1 writes all 64 bits. Otherwise, with `byte_wr_en` = 1, each set `byte_sel[i]` writes bits 8i+7..8i. Lanes that are not selected keep their old contents. A cycle with no lane written is a read.
- R7: A read whose controls are sampled at edge k drives data after edge k+1 when `pipe_mode` = 0, and after edge k+2 when `pipe_mode` = 1.
- R8: `dq_en` equals `oe` AND NOT `snooze` AND (returned read data present). It follows `oe` and `snooze` without waiting for a clock, and `dq_out` is zero whenever `dq_en` is low.
- R9: A cycle whose sampled `snooze` is high performs no read or write, leaves the beat counter and the start address unchanged, and keeps the array contents.
- R10: When `addr_strobe` and `advance` are both high in one cycle, the strobe takes priority: a new burst starts at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interleave_mode | input | 1 | 1 = interleaved (XOR) beat order, 0 = linear beat order |
| pipe_mode | input | 1 | 1 = extra output register, 0 = flow-through output |
| addr | input | ADDR_W | Burst start address |
| addr_strobe | input | 1 | Start a new burst at `addr` |
| advance | input | 1 | Step to the next beat of the current burst |
| wr_all | input | 1 | Write all eight bytes |
| byte_wr_en | input | 1 | Qualifies `byte_sel` for lane writes |
| byte_sel | input | BYTES | Per-lane write select |
| wdata | input | 8*BYTES | Write data |
| oe | input | 1 | Output enable, combinational |
| snooze | input | 1 | Low-power state request |
| dq_out | output | 8*BYTES | Read data, zero when not driven |
| dq_en | output | 1 | Output drive enable; low means high impedance |

## Verification
The bench drives `addr_strobe` and `advance` high in the same cycle to check that the strobe wins. It also raises `snooze` on cycles that would otherwise advance the burst or write a word. After snooze is released, the bench continues the burst. It then judges from the returned beat addresses whether the counter and the start address held. It also reads the word it tried to write, to confirm that the array kept its contents. A behavioural model stores its own copy of the array and schedules expected output by edge number. Each clock, the bench compares `dq_en` and `dq_out` against that model.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } beat_order_e;

    // Low two address bits for a given beat of a burst
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input beat_order_e order);
        logic [1:0] res;
        if (order == ORDER_INTERLEAVE) begin
            res = start ^ beat;
        end else begin
            res = start + beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_order_e       order,
    input  logic              strb,
    input  logic              adv,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              acc,
    output logic [ADDR_W-1:0] eff_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        beat;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [ADDR_W-1:0] start_sel;
    logic [1:0]        beat_sel;

    always_comb begin
        st_d      = st_q;
        acc       = 1'b0;
        start_sel = st_q.base;
        beat_sel  = st_q.beat;
        if (!sleep) begin
            if (strb) begin
                st_d.base = addr_in;
                st_d.beat = 2'd0;
                start_sel = addr_in;
                beat_sel  = 2'd0;
                acc       = 1'b1;
            end else if (adv) begin
                st_d.beat = st_q.beat + 2'd1;
                beat_sel  = st_d.beat;
                acc       = 1'b1;
            end
        end
        eff_addr = {start_sel[ADDR_W-1:2], beat_low(start_sel[1:0], beat_sel, order)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STRB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !sleep) |=> (st_q.beat == 2'd0)); // R2

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !strb && !sleep) |=> (st_q.beat == $past(st_q.beat) + 2'd1)); // R3

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(st_q.beat) && $stable(st_q.base))); // R9

endmodule

// File: rtl/sram_core.sv
module sram_core #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTES-1:0]     lane_mask,
    input  logic [8*BYTES-1:0]   wdata,
    output logic                 rd_valid,
    output logic [8*BYTES-1:0]   rd_data
);

    localparam int DATA_W = 8 * BYTES;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] data;
    } rd_port_t;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged;
    logic              do_write;
    logic              do_read;
    rd_port_t          rd_d, rd_q;

    assign cur_word = mem[addr];
    assign do_write = acc && (|lane_mask);
    assign do_read  = acc && !(|lane_mask);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign merged[8*b +: 8] = lane_mask[b] ? wdata[8*b +: 8] : cur_word[8*b +: 8];
    end

    always_comb begin
        rd_d   = rd_q;
        rd_d.v = do_read;
        if (do_read) begin
            rd_d.data = cur_word;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[addr] <= merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.v;
    assign rd_data  = rd_q.data;

    AST_WR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (|lane_mask)) |=> !rd_valid); // R6

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe,
    input  logic              oe,
    input  logic              snooze,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_en
);

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] data;
    } out_reg_t;

    out_reg_t pr_d, pr_q;
    logic              sel_v;
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        pr_d.v    = rd_valid;
        pr_d.data = rd_data;
        sel_v     = pipe ? pr_q.v    : rd_valid;
        sel_data  = pipe ? pr_q.data : rd_data;
        dq_en     = oe && !snooze && sel_v;
        dq_out    = dq_en ? sel_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    AST_PIPE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> pr_q.v); // R7

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 interleave_mode,
    input  logic                 pipe_mode,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 addr_strobe,
    input  logic                 advance,
    input  logic                 wr_all,
    input  logic                 byte_wr_en,
    input  logic [BYTES-1:0]     byte_sel,
    input  logic [8*BYTES-1:0]   wdata,
    input  logic                 oe,
    input  logic                 snooze,
    output logic [8*BYTES-1:0]   dq_out,
    output logic                 dq_en
);

    localparam int DATA_W = 8 * BYTES;

    typedef struct packed {
        logic              strb;
        logic              adv;
        logic              sleep;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  mask;
        logic [DATA_W-1:0] wdata;
    } in_reg_t;

    in_reg_t           in_d, in_q;
    logic              acc;
    logic [ADDR_W-1:0] eff_addr;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    beat_order_e       order;

    assign order = interleave_mode ? ORDER_INTERLEAVE : ORDER_LINEAR;

    always_comb begin
        in_d.strb  = addr_strobe;
        in_d.adv   = advance;
        in_d.sleep = snooze;
        in_d.addr  = addr;
        in_d.wdata = wdata;
        if (wr_all) begin
            in_d.mask = '1;
        end else if (byte_wr_en) begin
            in_d.mask = byte_sel;
        end else begin
            in_d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .order    (order),
        .strb     (in_q.strb),
        .adv      (in_q.adv),
        .sleep    (in_q.sleep),
        .addr_in  (in_q.addr),
        .acc      (acc),
        .eff_addr (eff_addr)
    );

    sram_core #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .addr      (eff_addr),
        .lane_mask (in_q.mask),
        .wdata     (in_q.wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pipe     (pipe_mode),
        .oe       (oe),
        .snooze   (snooze),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .dq_out   (dq_out),
        .dq_en    (dq_en)
    );

    AST_SLEEP_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        in_q.sleep |-> !acc); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rd_valid); // R1

endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

    localparam int AW = 6;
    localparam int NB = 8;
    localparam int DW = 8 * NB;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          interleave_mode = 1'b1;
    logic          pipe_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          addr_strobe = 1'b0;
    logic          advance = 1'b0;
    logic          wr_all = 1'b0;
    logic          byte_wr_en = 1'b0;
    logic [NB-1:0] byte_sel = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe = 1'b1;
    logic          snooze = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_en;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .BYTES(NB)) dut (
        .clk(clk), .rst_n(rst_n), .interleave_mode(interleave_mode),
        .pipe_mode(pipe_mode), .addr(addr), .addr_strobe(addr_strobe),
        .advance(advance), .wr_all(wr_all), .byte_wr_en(byte_wr_en),
        .byte_sel(byte_sel), .wdata(wdata), .oe(oe), .snooze(snooze),
        .dq_out(dq_out), .dq_en(dq_en)
    );

    // ---------------- behavioural reference ----------------
    logic [DW-1:0] mmem [WORDS];
    bit            exp_v [int];
    logic [DW-1:0] exp_d [int];
    int            m_base = 0, m_beat = 0;
    bit            p_strb = 0, p_adv = 0, p_sleep = 0;
    int            p_addr = 0;
    logic [NB-1:0] p_mask = '0;
    logic [DW-1:0] p_wdata = '0;
    int            k = 0;

    function automatic int beat_addr(int base, int beat, bit ilv);
        int lo;
        if (ilv) lo = (base % 4) ^ beat;
        else     lo = ((base % 4) + beat) % 4;
        return (base / 4) * 4 + lo;
    endfunction

    always @(posedge clk) begin
        #1;
        k++;
        if (!rst_n) begin
            m_base = 0; m_beat = 0;
            p_strb = 0; p_adv = 0; p_sleep = 0; p_mask = '0;
            checks++;
            if (dq_en !== 1'b0 || dq_out !== '0) begin
                fails++;
                $display("FAIL R1 reset: dq_en=%b dq_out=%h expected 0/0", dq_en, dq_out);
            end
        end else begin
            if (!p_sleep && (p_strb || p_adv)) begin
                int a;
                if (p_strb) begin
                    m_base = p_addr; m_beat = 0;
                end else begin
                    m_beat = (m_beat + 1) % 4;
                end
                a = beat_addr(m_base, m_beat, interleave_mode);
                if (p_mask != '0) begin
                    for (int b = 0; b < NB; b++)
                        if (p_mask[b]) mmem[a][8*b +: 8] = p_wdata[8*b +: 8];
                end else begin
                    exp_v[k + (pipe_mode ? 1 : 0)] = 1'b1;
                    exp_d[k + (pipe_mode ? 1 : 0)] = mmem[a];
                end
            end
            p_strb  = addr_strobe;
            p_adv   = advance;
            p_sleep = snooze;
            p_addr  = int'(addr);
            p_wdata = wdata;
            p_mask  = wr_all ? '1 : (byte_wr_en ? byte_sel : '0);
            begin
                bit            e_en;
                logic [DW-1:0] e_d;
                e_en = oe && !snooze && exp_v.exists(k);
                e_d  = e_en ? exp_d[k] : '0;
                checks++;
                if (dq_en !== e_en || dq_out !== e_d) begin
                    fails++;
                    $display("FAIL %s edge %0d: dq_en=%b dq_out=%h expected %b/%h",
                             cur_req, k, dq_en, dq_out, e_en, e_d);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(bit s, bit v, int a, bit wa, bit be, logic [NB-1:0] bs, logic [DW-1:0] wd);
        @(negedge clk);
        addr_strobe = s; advance = v; addr = AW'(a);
        wr_all = wa; byte_wr_en = be; byte_sel = bs; wdata = wd;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, '0, '0);
    endtask

    task automatic burst_read(int a, int advs);
        cyc(1, 0, a, 0, 0, '0, '0);
        for (int i = 0; i < advs; i++) cyc(0, 1, 0, 0, 0, '0, '0);
        idle(4);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;

        cur_req = "R6";   // fill with full-word writes
        for (int i = 0; i < WORDS; i++)
            cyc(1, 0, i, 1, 0, '0, {i[7:0], 8'hA5, 16'h1234, 24'hC0FFEE, ~i[7:0]});
        idle(3);

        cur_req = "R4";   // interleaved order from low bits 2 and 1
        interleave_mode = 1'b1;
        burst_read(6, 3);
        burst_read(13, 3);

        cur_req = "R5";   // linear order
        interleave_mode = 1'b0;
        burst_read(6, 3);
        burst_read(15, 3);

        cur_req = "R3";   // wrap beyond four beats
        burst_read(9, 6);

        cur_req = "R6";   // lane writes inside a burst, then read back
        cyc(1, 0, 20, 0, 1, 8'b1000_0001, {8{8'h11}});
        cyc(0, 1, 0, 0, 1, 8'b0011_0000, {8{8'h22}});
        cyc(0, 1, 0, 1, 0, '0, 64'hDEAD_BEEF_0BAD_F00D);
        cyc(0, 1, 0, 0, 1, 8'b0000_0000, {8{8'h33}});
        idle(2);
        burst_read(20, 3);

        cur_req = "R7";   // pipelined output
        pipe_mode = 1'b1;
        idle(3);
        interleave_mode = 1'b1;
        burst_read(5, 3);
        burst_read(40, 3);

        cur_req = "R10";  // strobe and advance together
        cyc(1, 0, 33, 0, 0, '0, '0);
        cyc(0, 1, 0, 0, 0, '0, '0);
        cyc(1, 1, 50, 0, 0, '0, '0);
        cyc(0, 1, 0, 0, 0, '0, '0);
        idle(4);

        cur_req = "R8";   // output enable gating
        cyc(1, 0, 44, 0, 0, '0, '0);
        cyc(0, 1, 0, 0, 0, '0, '0);
        @(negedge clk); advance = 1'b1; oe = 1'b0;
        @(negedge clk); oe = 1'b1;
        idle(3);
        cyc(1, 0, 45, 0, 0, '0, '0);
        idle(2);
        @(posedge clk); #1.5;
        oe = 1'b0; #0.1;
        checks++;
        if (dq_en !== 1'b0) begin
            fails++;
            $display("FAIL R8 async oe: dq_en=%b expected 0", dq_en);
        end
        oe = 1'b1; #0.1;
        idle(3);

        cur_req = "R9";   // snooze blocks advance and write
        pipe_mode = 1'b0;
        idle(2);
        cyc(1, 0, 24, 0, 0, '0, '0);
        cyc(0, 1, 0, 0, 0, '0, '0);
        @(negedge clk); advance = 1'b1; snooze = 1'b1;
        @(negedge clk); advance = 1'b1; wr_all = 1'b1; wdata = '1;
        @(negedge clk); snooze = 1'b0; wr_all = 1'b0;
        cyc(0, 1, 0, 0, 0, '0, '0);
        idle(3);
        cyc(1, 0, 60, 1, 0, '0, 64'h0123_4567_89AB_CDEF);
        @(negedge clk); addr_strobe = 1'b1; addr = AW'(60); snooze = 1'b1;
        wr_all = 1'b1; wdata = '0;
        @(negedge clk); snooze = 1'b0; addr_strobe = 1'b0; wr_all = 1'b0;
        idle(2);
        burst_read(60, 0);

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule